// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block follows atomic reservations for a cache that serves several requesters. Each completed memory request is presented for one cycle. The request carries a type, a byte address and a requester identifier. The block reduces the address to a line address and keeps a small fully associative table of locked lines. Each table entry records the requester that owns the line.

A locked read reserves its line for its requester. A locked write (store-conditional) reports whether that requester still holds the reservation. The locked write then removes the reservation in either case. A plain write removes a reservation only when the writer is the owner.

For read-modify-write pairs, the first half raises a block indication naming its line, so that further requests on that line stay queued. The second half drops that block. Every request receives a one-cycle response one clock later. The response carries the success bit and echoes the requester identifier.

Top module: `llsc_monitor`

## Requirements
- R1: Request type codes on `req_type_i` are: 0 load, 1 instruction fetch, 2 locked read, 3 locked write, 4 plain write, 5 read-modify-write read, 6 read-modify-write write. A locked read records a reservation on its line, owned by `req_id_i`.
- R2: A locked write succeeds only when its line holds a reservation owned by the same requester ID. A reservation held by another ID gives failure, and so does a line with no reservation.
- R3: The success bit of a locked-write response is 1 on success and 0 on failure.
- R4: Every locked write removes the reservation on its line, whether it succeeds or fails, so a repeated locked write fails.
- R5: A plain write removes the reservation on its line when the writer's ID owns it. A plain write from a different ID leaves the reservation in place.
- R6: Lookups and updates use the line address, which is the address with its low `OFFSET_W` bits dropped (64-byte lines by default). Two addresses in the same line refer to one reservation.
- R7: The table holds `ENTRIES` lines (8 by default). A locked read to a new line takes the lowest free entry. When the table is full, it replaces the entry under a round-robin pointer, which starts at entry 0 after reset and advances by one on each replacement.
- R8: Loads, instruction fetches, locked reads and all non-locked-write types respond with success 1. The response echoes the requester ID.
- R9: A request accepted on a clock edge produces `rsp_valid_o` high for exactly the following cycle. With no request, `rsp_valid_o` is low.
- R10: A read-modify-write read raises `blk_active_o` with `blk_line_o` set to its line. A read-modify-write write to that same line drops it. A read-modify-write write to a different line leaves the block in place.
- R11: The active-low asynchronous reset clears all reservations, the round-robin pointer, the block indication and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A completed request is present this cycle |
| req_type_i | input | 3 | Request type code |
| req_addr_i | input | ADDR_W | Byte address |
| req_id_i | input | ID_W | Requester identifier |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_success_o | output | 1 | 1 unless a locked write failed |
| rsp_id_o | output | ID_W | Echoed requester identifier |
| blk_active_o | output | 1 | A read-modify-write block is in force |
| blk_line_o | output | ADDR_W-OFFSET_W | Line address under block |

## Verification
The assertions take for granted that the request fields are known whenever `req_valid_i` is high. They also assume that only the codes 0 to 6 are presented, and that a read-modify-write read is closed by its own write before another read-modify-write read arrives. The directed stimulus drives each request for a single cycle, always from a defined type table. It pairs every read-modify-write read with a write, except in the test of a mismatched-line release and in the reset test, which are both followed by a reset.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    REQ_LOAD   = 3'd0,
    REQ_IFETCH = 3'd1,
    REQ_LL     = 3'd2,
    REQ_SC     = 3'd3,
    REQ_WRITE  = 3'd4,
    REQ_RMW_RD = 3'd5,
    REQ_RMW_WR = 3'd6
  } req_type_e;
endpackage

// File: rtl/llsc_lock_table.sv
module llsc_lock_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LINE_W  = 26,
  parameter int unsigned ID_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ll_i,
  input  logic              sc_i,
  input  logic              wr_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              hit_o
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [LINE_W-1:0]  line_q  [ENTRIES];
  logic [ID_W-1:0]    owner_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  logic [ENTRIES-1:0] line_match, own_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign line_match[g] = valid_q[g] && (line_q[g] == line_i);
    assign own_match[g]  = line_match[g] && (owner_q[g] == id_i);
  end

  assign hit_o = |own_match;

  logic             any_match, any_free;
  logic [PTR_W-1:0] match_idx, free_idx;

  always_comb begin
    any_match = 1'b0;
    any_free  = 1'b0;
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (line_match[i]) begin
        any_match = 1'b1;
        match_idx = PTR_W'(i);
      end
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = PTR_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        line_q[i]  <= '0;
        owner_q[i] <= '0;
      end
    end else if (ll_i) begin
      if (any_match) begin
        owner_q[match_idx] <= id_i;
      end else if (any_free) begin
        valid_q[free_idx] <= 1'b1;
        line_q[free_idx]  <= line_i;
        owner_q[free_idx] <= id_i;
      end else begin
        line_q[rr_q]  <= line_i;
        owner_q[rr_q] <= id_i;
        rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end else if (sc_i) begin
      valid_q <= valid_q & ~line_match;
    end else if (wr_i) begin
      valid_q <= valid_q & ~own_match;
    end
  end

  // R7
  no_dup_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_match));

  // R7
  rr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= PTR_W'(ENTRIES - 1));

  // R4
  sc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && !ll_i && any_match) |=> !valid_q[$past(match_idx)]);
endmodule

// File: rtl/llsc_rmw_block.sv
module llsc_rmw_block #(
  parameter int unsigned LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              rel_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              active_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      line_o   <= '0;
    end else if (set_i) begin
      active_o <= 1'b1;
      line_o   <= line_i;
    end else if (rel_i && active_o && line_o == line_i) begin
      active_o <= 1'b0;
    end
  end

  // R10
  rmw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (active_o && line_o == $past(line_i)));

  // R10
  rmw_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !set_i && !(rel_i && line_i == line_o)) |=> active_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned ENTRIES  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [2:0]                 req_type_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [ID_W-1:0]            req_id_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_success_o,
  output logic [ID_W-1:0]            rsp_id_o,
  output logic                       blk_active_o,
  output logic [ADDR_W-OFFSET_W-1:0] blk_line_o
);
  import llsc_pkg::*;

  localparam int unsigned LINE_W = ADDR_W - OFFSET_W;

  req_type_e         req_type;
  logic [LINE_W-1:0] line;
  logic              is_ll, is_sc, is_wr, is_rmw_rd, is_rmw_wr;
  logic              lock_hit;

  assign req_type  = req_type_e'(req_type_i);
  assign line      = req_addr_i[ADDR_W-1:OFFSET_W];
  wire   unused_offset = &{1'b0, req_addr_i[OFFSET_W-1:0]};

  assign is_ll     = req_valid_i && req_type == REQ_LL;
  assign is_sc     = req_valid_i && req_type == REQ_SC;
  assign is_wr     = req_valid_i && (req_type == REQ_WRITE || req_type == REQ_RMW_WR);
  assign is_rmw_rd = req_valid_i && req_type == REQ_RMW_RD;
  assign is_rmw_wr = req_valid_i && req_type == REQ_RMW_WR;

  llsc_lock_table #(
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W),
    .ID_W    (ID_W)
  ) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ll_i   (is_ll),
    .sc_i   (is_sc),
    .wr_i   (is_wr),
    .line_i (line),
    .id_i   (req_id_i),
    .hit_o  (lock_hit)
  );

  llsc_rmw_block #(
    .LINE_W (LINE_W)
  ) u_block (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (is_rmw_rd),
    .rel_i    (is_rmw_wr),
    .line_i   (line),
    .active_o (blk_active_o),
    .line_o   (blk_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_success_o <= 1'b0;
      rsp_id_o      <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_success_o <= !is_sc || lock_hit;
        rsp_id_o      <= req_id_i;
      end
    end
  end

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o && rsp_id_o == $past(req_id_i)));

  // R9
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R8
  non_sc_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type != REQ_SC) |=> rsp_success_o);

  // R4
  sc_twice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc |=> !lock_hit || !(is_sc && line == $past(line) && req_id_i == $past(req_id_i)));
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int ID_W = 4;
  localparam int LW   = 26;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [2:0]      req_type = '0;
  logic [31:0]     req_addr = '0;
  logic [ID_W-1:0] req_id = '0;
  logic            rsp_valid, rsp_success, blk_active;
  logic [ID_W-1:0] rsp_id;
  logic [LW-1:0]   blk_line;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [2:0] T_LOAD = 3'd0, T_IF = 3'd1, T_LL = 3'd2, T_SC = 3'd3,
                         T_WR = 3'd4, T_RR = 3'd5, T_RW = 3'd6;

  always #4 clk = ~clk;

  llsc_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_addr_i(req_addr), .req_id_i(req_id), .rsp_valid_o(rsp_valid),
    .rsp_success_o(rsp_success), .rsp_id_o(rsp_id), .blk_active_o(blk_active),
    .blk_line_o(blk_line)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one request; returns success bit sampled after the response edge
  task automatic req(input logic [2:0] t, input logic [31:0] a, input logic [ID_W-1:0] id,
                     output bit ok);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_id = id;
    @(posedge clk); #1;
    check(rsp_valid === 1'b1, "R9 rsp_valid", rsp_valid, 1);
    check(rsp_id === id, "R8 rsp_id", rsp_id, id);
    ok = rsp_success;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R11 rsp after reset", rsp_valid, 0);
    check(blk_active === 1'b0, "R11 blk after reset", blk_active, 0);
  endtask

  task automatic t_ll_sc();
    bit ok;
    req(T_LL, 32'h1000, 4'd1, ok);
    check(ok, "R1 LL success", ok, 1);
    req(T_SC, 32'h1000, 4'd1, ok);
    check(ok == 1, "R2 R3 SC own lock", ok, 1);
    req(T_SC, 32'h1000, 4'd1, ok);
    check(ok == 0, "R4 second SC fails", ok, 0);
    req(T_SC, 32'h2000, 4'd3, ok);
    check(ok == 0, "R2 SC no lock", ok, 0);
  endtask

  task automatic t_other_id();
    bit ok;
    req(T_LL, 32'h3000, 4'd1, ok);
    req(T_SC, 32'h3000, 4'd2, ok);
    check(ok == 0, "R2 R3 SC other id", ok, 0);
    req(T_SC, 32'h3000, 4'd1, ok);
    check(ok == 0, "R4 failed SC cleared lock", ok, 0);
  endtask

  task automatic t_plain_write();
    bit ok;
    req(T_LL, 32'h4000, 4'd5, ok);
    req(T_WR, 32'h4000, 4'd5, ok);
    req(T_SC, 32'h4000, 4'd5, ok);
    check(ok == 0, "R5 own write clears", ok, 0);
    req(T_LL, 32'h4000, 4'd5, ok);
    req(T_WR, 32'h4000, 4'd6, ok);
    req(T_SC, 32'h4000, 4'd5, ok);
    check(ok == 1, "R5 other write keeps", ok, 1);
  endtask

  task automatic t_line_mask();
    bit ok;
    req(T_LL, 32'h0000_0100, 4'd2, ok);
    req(T_SC, 32'h0000_013C, 4'd2, ok);
    check(ok == 1, "R6 same line offset", ok, 1);
    req(T_LL, 32'h0000_0100, 4'd2, ok);
    req(T_SC, 32'h0000_0140, 4'd2, ok);
    check(ok == 0, "R6 next line", ok, 0);
  endtask

  task automatic t_capacity();
    bit ok;
    do_reset();
    for (int i = 0; i < 9; i++) req(T_LL, 32'(i) << 6, 4'd7, ok);
    req(T_SC, 32'h0, 4'd7, ok);
    check(ok == 0, "R7 slot0 replaced", ok, 0);
    req(T_SC, 32'h40, 4'd7, ok);
    check(ok == 1, "R7 line1 kept", ok, 1);
    req(T_SC, 32'h200, 4'd7, ok);
    check(ok == 1, "R7 new line held", ok, 1);
  endtask

  task automatic t_success_types();
    bit ok;
    req(T_LOAD, 32'h500, 4'd9, ok);
    check(ok == 1, "R8 load success", ok, 1);
    req(T_IF, 32'h540, 4'd10, ok);
    check(ok == 1, "R8 ifetch success", ok, 1);
    req(T_WR, 32'h580, 4'd11, ok);
    check(ok == 1, "R8 write success", ok, 1);
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R9 idle no response", rsp_valid, 0);
  endtask

  task automatic t_rmw();
    bit ok;
    req(T_RR, 32'h0000_8040, 4'd3, ok);
    check(blk_active === 1'b1, "R10 block raised", blk_active, 1);
    check(blk_line === 26'h0000_8040 >> 6, "R10 block line", blk_line, 26'h0000_8040 >> 6);
    req(T_RW, 32'h0000_9000, 4'd3, ok);
    check(blk_active === 1'b1, "R10 other line keeps", blk_active, 1);
    req(T_RW, 32'h0000_8050, 4'd3, ok);
    check(blk_active === 1'b0, "R10 release", blk_active, 0);
  endtask

  task automatic t_reset_clears();
    bit ok;
    req(T_LL, 32'h6000, 4'd4, ok);
    req(T_RR, 32'h7000, 4'd4, ok);
    do_reset();
    @(posedge clk); #1;
    check(blk_active === 1'b0, "R11 block cleared", blk_active, 0);
    req(T_SC, 32'h6000, 4'd4, ok);
    check(ok == 0, "R11 lock cleared", ok, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ll_sc();
    t_other_id();
    t_plain_write();
    t_line_mask();
    t_capacity();
    t_success_types();
    t_rmw();
    t_reset_clears();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule